// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Controller

This block decides, cycle by cycle, what each output of a clock generator's output bank should do: pass its clock, sit driven low, sit driven high, or float. The bank holds two CPU pairs, one pair that serves either as a CPU debug pair or as a seventh SRC pair, six SRC pairs, a SATA pair, six stoppable PCI outputs, two PCI outputs that can be set free-running, a 48 MHz USB output, a 96 MHz DOT pair and two REF outputs. Clock synthesis and the analog buffers are outside the block; they consume the per-output state it produces.

A single power-good/power-down pin has two roles. Before the part is armed, a low level on the pin is the power-good strobe. While it is low, the frequency-select, test-select and debug-select straps are captured, and the block is armed. Once armed, the same pin is a live active-high power-down request. Software controls arrive as plain configuration inputs: per-output enables, per-output free-run bits, per-output power-down float bits, a stop float bit, the PCI run/stop bit and a test-mode force bit. Every change into or out of the running state waits for the output's own low phase, which is reported on `ph_hi`. A restart counter holds the bank off for a stabilization interval after power-down is released.

Top module: `clkout_pwr_ctl`

## Requirements
- R1: While unarmed, a low sampled on `pgpd_pin` captures `fsel_i`, `tsel_i` and `itp_sel_i` and arms the block. After that, `fsel_o` and `itp_mode_o` ignore the strap inputs until the next reset.
- R2: Output index 2 is the shared pair. With the debug strap captured as 1 it ignores PCI stop, as a CPU pair does. With the strap captured as 0 it stops like an SRC pair.
- R3: Test mode puts every output in HIZ (code 3). It is entered by a captured test strap of 1 or by a pulse on `cfg_test_force`, and only a reset with the strap at 0 leaves it.
- R4: An output whose `cfg_en` bit is 0 is HIZ. This overrides every state except test mode, and test mode also gives HIZ.
- R5: Before the block is armed, every output is LOW (code 1).
- R6: With `cfg_pci_run`=0, the stoppable outputs stop. These are PCI indices 10-15, plus the following with `cfg_free` clear: PCI indices 16-17, SRC/SATA indices 3-9, and index 2 in SRC mode. Stopped PCI outputs go LOW. Stopped pairs go HIZ if `cfg_stop_tri`=1 and LOW otherwise. All other outputs stay RUN (code 0).
- R7: While armed with `pgpd_pin` high (power-down), the differential pairs go HIZ if their `cfg_pd_tri` bit is 1 and LOW otherwise. These pairs are indices 0-9 and 19. The single-ended outputs (10-18, 20-21) go LOW.
- R8: `vco_off_o` rises only after power-down is requested and no output is RUN. It clears on the cycle after the pin is sampled low.
- R9: After the pin returns low, outputs keep their power-down state for STAB_CYC cycles. On the following cycle, driven-low pairs run, and pairs that floated are driven HIGH (code 2) for exactly one cycle before they run.
- R10: An output enters or leaves RUN only on a clock edge where its `ph_hi` bit is 0. While that bit is 1 it keeps its RUN or non-RUN status.
- R11: Reset gives every output LOW, `fsel_o`=0, `itp_mode_o`=0 and `vco_off_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset (power cycle) |
| pgpd_pin | input | 1 | Power-good strobe (low) before arming, power-down request (high) after |
| fsel_i | input | 3 | Frequency-select straps |
| tsel_i | input | 1 | Test-select strap |
| itp_sel_i | input | 1 | Shared-pair role strap, 1 selects CPU debug |
| cfg_test_force | input | 1 | Software test-mode entry (sticky) |
| cfg_pci_run | input | 1 | 1 runs the PCI/SRC bank, 0 stops stoppable outputs |
| cfg_stop_tri | input | 1 | Stopped pairs float (1) or drive low (0) |
| cfg_en | input | 22 | Per-output enable, 0 floats the output |
| cfg_free | input | 22 | Per-output free-run selection |
| cfg_pd_tri | input | 22 | Per-pair power-down float selection |
| ph_hi | input | 22 | Per-output clock phase, 1 while high |
| out_st | output | 44 | Two-bit state per output: 0 RUN, 1 LOW, 2 HIGH, 3 HIZ |
| fsel_o | output | 3 | Captured frequency select |
| itp_mode_o | output | 1 | Captured shared-pair role |
| vco_off_o | output | 1 | Oscillator may be shut down |

## Verification
A table of patterns sweeps the run/stop bit, the stop float bit, the free-run mask, the enable mask and power-down with all-driven, all-floated and alternating float masks. These cases separate PCI-stop behaviour from power-down behaviour and separate free-running from stoppable outputs. Directed runs count the restart cycles exactly, so a timer that is one cycle early or late is caught. They also show the one-cycle drive-high step only on floated pairs. Holding one output's phase high shows that gating and the oscillator shutdown both wait for that output. Resets with different straps check the latched roles and the stickiness of test mode.

// File: rtl/ckg_pkg.sv
// Package: shared output map, state encoding and output kinds for the
// clock output gating controller. Assumes a fixed bank layout; the counts
// below set every index used by the RTL.
package ckg_pkg;
    localparam int N_CPU  = 2;
    localparam int N_SRC  = 6;
    localparam int N_PCI  = 6;
    localparam int N_PCIF = 2;
    localparam int N_REF  = 2;

    localparam int IX_SHR  = N_CPU;
    localparam int IX_SRC  = IX_SHR + 1;
    localparam int IX_SATA = IX_SRC + N_SRC;
    localparam int IX_PCI  = IX_SATA + 1;
    localparam int IX_PCIF = IX_PCI + N_PCI;
    localparam int IX_USB  = IX_PCIF + N_PCIF;
    localparam int IX_DOT  = IX_USB + 1;
    localparam int IX_REF  = IX_DOT + 1;
    localparam int N_OUT   = IX_REF + N_REF;

    typedef enum logic [1:0] {
        OS_RUN  = 2'd0,
        OS_LOW  = 2'd1,
        OS_HIGH = 2'd2,
        OS_HIZ  = 2'd3
    } out_state_e;

    typedef enum logic [2:0] {
        KC_CPU, KC_SHARED, KC_SRC, KC_PCI, KC_PCIF, KC_USB, KC_DOT, KC_REF
    } out_kind_e;

    // Map an output index to its kind.
    function automatic out_kind_e kind_of(int idx);
        if (idx < IX_SHR)       return KC_CPU;
        else if (idx == IX_SHR) return KC_SHARED;
        else if (idx < IX_PCI)  return KC_SRC;
        else if (idx < IX_PCIF) return KC_PCI;
        else if (idx < IX_USB)  return KC_PCIF;
        else if (idx == IX_USB) return KC_USB;
        else if (idx == IX_DOT) return KC_DOT;
        else                    return KC_REF;
    endfunction

    // True for current-mode differential pairs.
    function automatic bit is_diff(out_kind_e k);
        return (k == KC_CPU) || (k == KC_SHARED) || (k == KC_SRC) || (k == KC_DOT);
    endfunction
endpackage

// File: rtl/ckg_strap_latch.sv
// Strap capture and pin role switch. Before arming, a low pin level
// captures the straps and arms; afterwards the pin is a power-down request.
// Test mode is sticky until reset. Assumes the pin is already synchronized.
module ckg_strap_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [2:0] fs_i,
    input  logic       test_i,
    input  logic       itp_i,
    input  logic       reg_test_i,
    output logic       armed_o,
    output logic [2:0] fs_o,
    output logic       itp_o,
    output logic       test_o,
    output logic       pd_req_o
);
    logic       armed_q;
    logic [2:0] fs_q;
    logic       itp_q;
    logic       tstrap_q;
    logic       treg_q;

    // Capture straps on the first low pin level while unarmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            fs_q     <= '0;
            itp_q    <= 1'b0;
            tstrap_q <= 1'b0;
        end else if (!armed_q && !pin_i) begin
            armed_q  <= 1'b1;
            fs_q     <= fs_i;
            itp_q    <= itp_i;
            tstrap_q <= test_i;
        end
    end

    // Software test entry, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          treg_q <= 1'b0;
        else if (reg_test_i) treg_q <= 1'b1;
    end

    assign armed_o  = armed_q;
    assign fs_o     = fs_q;
    assign itp_o    = itp_q;
    assign test_o   = tstrap_q | treg_q;
    assign pd_req_o = armed_q & pin_i;

    // R1
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(armed_q) |-> $stable(fs_q) && $stable(itp_q) && armed_q);
    // R3
    test_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(test_o) |-> test_o);
endmodule

// File: rtl/ckg_restart_timer.sv
// Power-down hold and restart sequencer. Holds the bank off while power-down
// is requested and for STAB_CYC cycles after release, then issues a one-cycle
// kick used to drive floated pairs high before they run.
module ckg_restart_timer #(
    parameter int STAB_CYC = 25776
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req_i,
    output logic hold_o,
    output logic kick_o
);
    localparam int CW = $clog2(STAB_CYC + 1);

    logic          hold_q;
    logic          kick_q;
    logic [CW-1:0] cnt_q;

    // Hold, count the stabilization window, then pulse kick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            kick_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            kick_q <= 1'b0;
            if (pd_req_i) begin
                hold_q <= 1'b1;
                cnt_q  <= '0;
            end else if (hold_q) begin
                if (cnt_q == CW'(STAB_CYC - 1)) begin
                    hold_q <= 1'b0;
                    kick_q <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign hold_o = hold_q;
    assign kick_o = kick_q;

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(STAB_CYC));
    // R9
    kick_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && kick_q |-> $past(hold_q) && !hold_q);
    // R7
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req_i |=> hold_q);
endmodule

// File: rtl/ckg_out_policy.sv
// Per-output target state. Pure combinational priority: test, enable,
// unarmed, power-down hold, restart kick, PCI stop, run. One slice per
// output, specialised by the output's kind.
module ckg_out_policy
    import ckg_pkg::*;
(
    input  logic             test_i,
    input  logic             armed_i,
    input  logic             hold_i,
    input  logic             kick_i,
    input  logic             itp_i,
    input  logic             pci_run_i,
    input  logic             stop_tri_i,
    input  logic [N_OUT-1:0] en_i,
    input  logic [N_OUT-1:0] free_i,
    input  logic [N_OUT-1:0] pd_tri_i,
    output out_state_e       tgt_o [N_OUT]
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_slice
        localparam out_kind_e K   = kind_of(i);
        localparam bit        DIF = is_diff(K);
        localparam bit        SE  = (K == KC_PCI) || (K == KC_PCIF);

        logic stoppable;

        // Whether PCI stop applies to this output.
        always_comb begin
            case (K)
                KC_PCI:           stoppable = 1'b1;
                KC_PCIF, KC_SRC:  stoppable = !free_i[i];
                KC_SHARED:        stoppable = !itp_i && !free_i[i];
                default:          stoppable = 1'b0;
            endcase
        end

        // Priority selection of the wanted state.
        always_comb begin
            if (test_i || !en_i[i])            tgt_o[i] = OS_HIZ;
            else if (!armed_i)                 tgt_o[i] = OS_LOW;
            else if (hold_i)                   tgt_o[i] = (DIF && pd_tri_i[i]) ? OS_HIZ : OS_LOW;
            else if (kick_i && DIF && pd_tri_i[i]) tgt_o[i] = OS_HIGH;
            else if (!pci_run_i && stoppable)  tgt_o[i] = (!SE && stop_tri_i) ? OS_HIZ : OS_LOW;
            else                               tgt_o[i] = OS_RUN;
        end
    end
endmodule

// File: rtl/ckg_out_gate.sv
// Glitch-free state register for one output. Moves into or out of RUN only
// while the output clock is in its low phase; moves between static states
// at once.
module ckg_out_gate
    import ckg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  out_state_e tgt_i,
    input  logic       ph_hi_i,
    output out_state_e st_o
);
    out_state_e st_q;

    // Follow the target, deferring run edges to the low phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= OS_LOW;
        else if (!(ph_hi_i && (st_q == OS_RUN || tgt_i == OS_RUN)))
            st_q <= tgt_i;
    end

    assign st_o = st_q;

    // R10
    low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (st_q != $past(st_q)) && (st_q == OS_RUN || $past(st_q) == OS_RUN)
        |-> !$past(ph_hi_i));
endmodule

// File: rtl/clkout_pwr_ctl.sv
// Top of the clock output gating and power-down controller. Ties the strap
// latch, restart timer, per-output policy and per-output gates, and derives
// the oscillator shutdown flag. Assumes all inputs are synchronous to clk.
module clkout_pwr_ctl
    import ckg_pkg::*;
#(
    parameter int STAB_CYC = 25776
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pgpd_pin,
    input  logic [2:0]         fsel_i,
    input  logic               tsel_i,
    input  logic               itp_sel_i,
    input  logic               cfg_test_force,
    input  logic               cfg_pci_run,
    input  logic               cfg_stop_tri,
    input  logic [N_OUT-1:0]   cfg_en,
    input  logic [N_OUT-1:0]   cfg_free,
    input  logic [N_OUT-1:0]   cfg_pd_tri,
    input  logic [N_OUT-1:0]   ph_hi,
    output logic [2*N_OUT-1:0] out_st,
    output logic [2:0]         fsel_o,
    output logic               itp_mode_o,
    output logic               vco_off_o
);
    logic       armed, itp, test_mode, pd_req, hold, kick;
    logic       any_run;
    logic       vco_q;
    out_state_e tgt [N_OUT];
    out_state_e st  [N_OUT];

    ckg_strap_latch u_strap (
        .clk(clk), .rst_n(rst_n), .pin_i(pgpd_pin), .fs_i(fsel_i),
        .test_i(tsel_i), .itp_i(itp_sel_i), .reg_test_i(cfg_test_force),
        .armed_o(armed), .fs_o(fsel_o), .itp_o(itp), .test_o(test_mode),
        .pd_req_o(pd_req)
    );

    ckg_restart_timer #(.STAB_CYC(STAB_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .pd_req_i(pd_req),
        .hold_o(hold), .kick_o(kick)
    );

    ckg_out_policy u_policy (
        .test_i(test_mode), .armed_i(armed), .hold_i(hold), .kick_i(kick),
        .itp_i(itp), .pci_run_i(cfg_pci_run), .stop_tri_i(cfg_stop_tri),
        .en_i(cfg_en), .free_i(cfg_free), .pd_tri_i(cfg_pd_tri), .tgt_o(tgt)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        ckg_out_gate u_gate (
            .clk(clk), .rst_n(rst_n), .tgt_i(tgt[i]), .ph_hi_i(ph_hi[i]),
            .st_o(st[i])
        );
        assign out_st[2*i +: 2] = st[i];
    end

    // Any output still passing its clock.
    always_comb begin
        any_run = 1'b0;
        for (int i = 0; i < N_OUT; i++) begin
            if (st[i] == OS_RUN) any_run = 1'b1;
        end
    end

    // Oscillator may stop once power-down holds and every output is quiet.
    always_ff @(posedge clk) begin
        if (!rst_n) vco_q <= 1'b0;
        else        vco_q <= hold && pd_req && !any_run;
    end

    assign itp_mode_o = itp;
    assign vco_off_o  = vco_q;

    // R8
    vco_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vco_q |-> !any_run && hold);
    // R5
    unarmed_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !armed && !test_mode |-> !any_run);
endmodule

// File: tb/clkout_pwr_ctl_tb_top.sv
module clkout_pwr_ctl_tb_top;
    localparam int N  = 22;
    localparam int S  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pgpd_pin = 1'b1;
    logic [2:0] fsel_i = '0;
    logic tsel_i = 1'b0, itp_sel_i = 1'b0, cfg_test_force = 1'b0;
    logic cfg_pci_run = 1'b1, cfg_stop_tri = 1'b0;
    logic [N-1:0] cfg_en = '1, cfg_free = '0, cfg_pd_tri = '0, ph_hi = '0;
    logic [2*N-1:0] out_st;
    logic [2:0] fsel_o;
    logic itp_mode_o, vco_off_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    clkout_pwr_ctl #(.STAB_CYC(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .pgpd_pin(pgpd_pin), .fsel_i(fsel_i),
        .tsel_i(tsel_i), .itp_sel_i(itp_sel_i), .cfg_test_force(cfg_test_force),
        .cfg_pci_run(cfg_pci_run), .cfg_stop_tri(cfg_stop_tri), .cfg_en(cfg_en),
        .cfg_free(cfg_free), .cfg_pd_tri(cfg_pd_tri), .ph_hi(ph_hi),
        .out_st(out_st), .fsel_o(fsel_o), .itp_mode_o(itp_mode_o),
        .vco_off_o(vco_off_o)
    );

    typedef struct packed {
        logic         pd;
        logic         run;
        logic         stri;
        logic [N-1:0] en;
        logic [N-1:0] free;
        logic [N-1:0] ptri;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b0, 1'b1, 1'b0, 22'h3FFFFF, 22'h000000, 22'h000000},
        '{1'b0, 1'b0, 1'b0, 22'h3FFFFF, 22'h000000, 22'h000000},
        '{1'b0, 1'b0, 1'b1, 22'h3FFFFF, 22'h015A2C, 22'h000000},
        '{1'b0, 1'b0, 1'b1, 22'h3FFFFF, 22'h3FFFFF, 22'h000000},
        '{1'b1, 1'b1, 1'b0, 22'h3FFFFF, 22'h000000, 22'h000000},
        '{1'b1, 1'b1, 1'b0, 22'h3FFFFF, 22'h000000, 22'h3FFFFF},
        '{1'b1, 1'b0, 1'b1, 22'h3FFFFF, 22'h000000, 22'h2AAAAA},
        '{1'b0, 1'b1, 1'b0, 22'h3F0FF0, 22'h000000, 22'h000000},
        '{1'b0, 1'b0, 1'b1, 22'h1FFF7E, 22'h030100, 22'h000000}
    };

    // Expected state per R4, R6, R7 (0 RUN, 1 LOW, 3 HIZ).
    function automatic logic [2*N-1:0] model(vec_t v, bit itp);
        logic [2*N-1:0] r;
        for (int i = 0; i < N; i++) begin
            bit diff = (i <= 9) || (i == 19);
            bit se   = (i >= 10) && (i <= 17);
            bit stp  = ((i >= 10) && (i <= 15)) || ((i >= 16) && (i <= 17) && !v.free[i]) ||
                       ((i >= 3) && (i <= 9) && !v.free[i]) || ((i == 2) && !itp && !v.free[i]);
            logic [1:0] s;
            if (!v.en[i])          s = 2'd3;
            else if (v.pd)         s = (diff && v.ptri[i]) ? 2'd3 : 2'd1;
            else if (!v.run && stp) s = se ? 2'd1 : (v.stri ? 2'd3 : 2'd1);
            else                   s = 2'd0;
            r[2*i +: 2] = s;
        end
        return r;
    endfunction

    function automatic logic [2*N-1:0] fill(logic [1:0] s);
        logic [2*N-1:0] r;
        for (int i = 0; i < N; i++) r[2*i +: 2] = s;
        return r;
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [1:0] sti(int i);
        return out_st[2*i +: 2];
    endfunction

    task automatic do_reset(bit tsel, bit itp, logic [2:0] fs);
        rst_n = 1'b0; pgpd_pin = 1'b1; tsel_i = tsel; itp_sel_i = itp; fsel_i = fs;
        cfg_test_force = 1'b0; cfg_pci_run = 1'b1; cfg_stop_tri = 1'b0;
        cfg_en = '1; cfg_free = '0; cfg_pd_tri = '0; ph_hi = '0;
        step(3);
        rst_n = 1'b1;
        step(2);
    endtask

    task automatic arm();
        pgpd_pin = 1'b0;
        step(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11 reset values
        step(3);
        chk("R11 out_st", out_st, fill(2'd1));
        chk("R11 fsel/itp/vco", {fsel_o, itp_mode_o, vco_off_o}, 5'b0);
        rst_n = 1'b1;
        fsel_i = 3'b101;
        step(5);
        // R5 unarmed outputs low
        chk("R5 unarmed", out_st, fill(2'd1));
        arm();
        // R1 strap capture, then ignored
        chk("R1 capture", {fsel_o, itp_mode_o}, {3'b101, 1'b0});
        fsel_i = 3'b010; itp_sel_i = 1'b1;
        step(3);
        chk("R1 straps ignored", {fsel_o, itp_mode_o}, {3'b101, 1'b0});
        chk("R1 running after arm", out_st, fill(2'd0));
        itp_sel_i = 1'b0;

        // Table walk: R4 R6 R7
        foreach (VECS[k]) begin
            cfg_en = VECS[k].en; cfg_free = VECS[k].free; cfg_pd_tri = VECS[k].ptri;
            cfg_pci_run = VECS[k].run; cfg_stop_tri = VECS[k].stri;
            pgpd_pin = VECS[k].pd;
            step(S + 6);
            chk($sformatf("R6/R7/R4 vector %0d", k), out_st, model(VECS[k], 1'b0));
            if (VECS[k].pd) chk("R8 vco off in pd", vco_off_o, 1'b1);
        end

        // R9 exact restart timing: index 0 floated, index 1 driven
        cfg_en = '1; cfg_free = '0; cfg_pci_run = 1'b1; cfg_stop_tri = 1'b0;
        cfg_pd_tri = 22'h000001;
        pgpd_pin = 1'b1;
        step(6);
        chk("R7 pd float/drive", {sti(0), sti(1)}, {2'd3, 2'd1});
        pgpd_pin = 1'b0;
        step(1);
        chk("R8 vco clears on release", vco_off_o, 1'b0);
        step(S - 1);
        chk("R9 held for window", {sti(0), sti(1)}, {2'd3, 2'd1});
        step(1);
        chk("R9 float pair high, driven pair runs", {sti(0), sti(1)}, {2'd2, 2'd0});
        step(1);
        chk("R9 float pair runs", {sti(0), sti(1)}, {2'd0, 2'd0});

        // R10 and R8: USB phase held high delays its stop and the VCO shutdown
        cfg_pd_tri = '0;
        ph_hi = 22'h040000;
        pgpd_pin = 1'b1;
        step(5);
        chk("R10 USB stays running in high phase", sti(18), 2'd0);
        chk("R8 vco waits for USB", vco_off_o, 1'b0);
        ph_hi = '0;
        step(1);
        chk("R10 USB stops in low phase", sti(18), 2'd1);
        step(1);
        chk("R8 vco off after all quiet", vco_off_o, 1'b1);
        ph_hi = 22'h040000;
        pgpd_pin = 1'b0;
        step(S + 4);
        chk("R10 USB restart deferred", {sti(18), sti(10)}, {2'd1, 2'd0});
        ph_hi = '0;
        step(1);
        chk("R10 USB restarts in low phase", sti(18), 2'd0);

        // R2 shared pair as CPU debug pair
        do_reset(1'b0, 1'b1, 3'b011);
        arm();
        chk("R2 itp latched", itp_mode_o, 1'b1);
        cfg_pci_run = 1'b0;
        step(3);
        chk("R2 shared pair ignores stop", {sti(2), sti(3)}, {2'd0, 2'd1});
        // R2 shared pair as SRC
        do_reset(1'b0, 1'b0, 3'b011);
        arm();
        cfg_pci_run = 1'b0;
        step(3);
        chk("R2 shared pair stops as SRC", sti(2), 2'd1);

        // R3 test strap
        do_reset(1'b1, 1'b0, 3'b000);
        arm();
        chk("R3 strap test mode", out_st, fill(2'd3));
        // R3 software force, sticky
        do_reset(1'b0, 1'b0, 3'b000);
        arm();
        chk("R3 normal before force", out_st, fill(2'd0));
        cfg_test_force = 1'b1;
        step(1);
        cfg_test_force = 1'b0;
        step(4);
        chk("R3 forced test mode sticky", out_st, fill(2'd3));
        pgpd_pin = 1'b1;
        step(4);
        chk("R3 test overrides pd", out_st, fill(2'd3));
        do_reset(1'b0, 1'b0, 3'b000);
        arm();
        chk("R3 reset leaves test mode", out_st, fill(2'd0));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule